// File: doc/BRIEF.md
# I2C Single-Byte Transaction Sequencer

This block is the protocol layer of an I2C master. It turns one request (a 7-bit target address, a direction flag and, for a write, one data byte) into a fixed series of bit-level primitives. A separate bit engine carries out each primitive and owns all SCL/SDA timing, clock-stretch waits and pin drive. The sequencer holds no bus timing of its own. It presents one command at a time and steps forward only when the engine reports that the command has completed.

A write transaction runs START, the address bits, the direction bit, the address acknowledge, eight data bits, the data acknowledge, then STOP. A read transaction replaces the data phase with eight received bits and a master NACK before STOP.

A negative acknowledge from the target cuts the transaction short to STOP and raises an error flag. An arbitration loss reported by the engine ends the transaction at once, with no STOP sent, so that the winning master's traffic is not disturbed. The loss flag stays set until the next request is accepted.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `be_req_o`, `done_o`, `nack_o` and `arb_lost_o` are low, and `be_cmd_o` is 0.
- R2: An accepted start issues, in this order: START, then the 7 address bits MSB first as SEND_BIT, then the direction bit as SEND_BIT (1 = read), then RECV_ACK. The command codes are NONE=0, START=1, STOP=2, SEND_BIT=3, RECV_BIT=4, SEND_ACK=5, RECV_ACK=6. `be_bit_o` carries the bit to send.
- R3: While `be_req_o` is high and `be_done_i` is low, the command and `be_bit_o` hold steady. The sequence advances only on a cycle where `be_done_i` is high.
- R4: On a write with the address acknowledged (`be_rx_i`=0), the block sends the 8 data bits MSB first, then RECV_ACK, then STOP.
- R5: On a read with the address acknowledged, the block issues 8 RECV_BIT commands and assembles `be_rx_i` MSB first into `rdata_o`. It then issues SEND_ACK with bit 1 (NACK), then STOP.
- R6: A high `be_rx_i` on the address or data RECV_ACK sets `nack_o`, and the next command is STOP.
- R7: If `be_arb_i` is high on any completion, no further command is issued (no STOP), `done_o` follows, and `arb_lost_o` is set. `arb_lost_o` and `nack_o` stay as they are until the next accepted start, which clears them.
- R8: `busy_o` is high from the cycle after an accepted start through the single-cycle `done_o` pulse. The block is idle in the cycle after `done_o`.
- R9: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a transaction (taken only when idle) |
| addr_i | input | ADDR_W | Target address |
| rd_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | DATA_W | Byte to write |
| be_req_o | output | 1 | A command is presented to the bit engine |
| be_cmd_o | output | 3 | Command code |
| be_bit_o | output | 1 | Bit to send for SEND_BIT / SEND_ACK |
| be_done_i | input | 1 | Engine completed the current command |
| be_rx_i | input | 1 | Bit sampled by the engine, valid with done |
| be_arb_i | input | 1 | Engine lost arbitration, valid with done |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | DATA_W | Byte received on a read |
| nack_o | output | 1 | Target answered NACK |
| arb_lost_o | output | 1 | Sticky arbitration-loss flag |

## Verification
The bench models the bit engine with a configurable response delay and logs every completed command. It compares that log with a sequence rebuilt from the requirements. The cases covered are:

- **Arbitration loss.** Losses are placed on the START itself, on an address bit and on a read bit. A design that still sent STOP, or kept issuing bits after a loss, would show a longer command log.
- **NACK.** Address and data NACKs are tested. A sequencer that ignored them would carry on into the data phase instead of going to STOP.
- **Slow engine.** A long engine delay exposes any command or bit that changes before completion.
- **Start during a transaction.** A second start pulse mid-transaction would corrupt the log if it were not ignored.
- **Sticky flags.** The flags are checked to clear exactly when the next request is accepted.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_START    = 3'd1,
    CMD_STOP     = 3'd2,
    CMD_SEND_BIT = 3'd3,
    CMD_RECV_BIT = 3'd4,
    CMD_SEND_ACK = 3'd5,
    CMD_RECV_ACK = 3'd6
  } bcmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_RW, ST_AACK, ST_WDATA,
    ST_WACK, ST_RDATA, ST_MACK, ST_STOP, ST_DONE
  } txn_st_e;

  // Command presented to the bit engine in each sequencer state.
  function automatic bcmd_e cmd_for(txn_st_e s);
    case (s)
      ST_START:                   return CMD_START;
      ST_ADDR, ST_RW, ST_WDATA:   return CMD_SEND_BIT;
      ST_AACK, ST_WACK:           return CMD_RECV_ACK;
      ST_RDATA:                   return CMD_RECV_BIT;
      ST_MACK:                    return CMD_SEND_ACK;
      ST_STOP:                    return CMD_STOP;
      default:                    return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/i2c_txn_fsm.sv
module i2c_txn_fsm
  import i2c_txn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  logic    step,
  input  logic    rx_bit,
  input  logic    arb,
  input  logic    rd_q,
  input  logic    cnt_zero,
  output txn_st_e state
);

  txn_st_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (accept) nxt = ST_START;
      ST_DONE: nxt = ST_IDLE;
      default: if (step) begin
        if (arb) nxt = ST_DONE;
        else begin
          case (state)
            ST_START: nxt = ST_ADDR;
            ST_ADDR:  nxt = cnt_zero ? ST_RW : ST_ADDR;
            ST_RW:    nxt = ST_AACK;
            ST_AACK:  nxt = rx_bit ? ST_STOP : (rd_q ? ST_RDATA : ST_WDATA);
            ST_WDATA: nxt = cnt_zero ? ST_WACK : ST_WDATA;
            ST_WACK:  nxt = ST_STOP;
            ST_RDATA: nxt = cnt_zero ? ST_MACK : ST_RDATA;
            ST_MACK:  nxt = ST_STOP;
            ST_STOP:  nxt = ST_DONE;
            default:  nxt = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/i2c_txn_data.sv
module i2c_txn_data
  import i2c_txn_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txn_st_e           state,
  input  logic              accept,
  input  logic              step,
  input  logic              rx_bit,
  input  logic              arb,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tx_bit,
  output logic              cnt_zero,
  output logic              rd_q,
  output logic [DATA_W-1:0] rdata,
  output logic              nack,
  output logic              arb_lost
);

  localparam int SH_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = (SH_W > 2) ? $clog2(SH_W) : 1;

  logic [SH_W-1:0]   shreg;
  logic [DATA_W-1:0] wbuf;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [CNT_W-1:0] cnt_dec(logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] shift_in(logic [DATA_W-1:0] v, logic b);
    return {v[DATA_W-2:0], b};
  endfunction

  assign cnt_zero = (cnt == '0);

  always_comb begin
    case (state)
      ST_ADDR, ST_WDATA: tx_bit = shreg[SH_W-1];
      ST_RW:             tx_bit = rd_q;
      default:           tx_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      wbuf     <= '0;
      cnt      <= '0;
      rd_q     <= 1'b0;
      rdata    <= '0;
      nack     <= 1'b0;
      arb_lost <= 1'b0;
    end else if (accept) begin
      shreg    <= SH_W'(addr_i) << (SH_W - ADDR_W);
      wbuf     <= wdata_i;
      cnt      <= CNT_W'(ADDR_W - 1);
      rd_q     <= rd_i;
      nack     <= 1'b0;
      arb_lost <= 1'b0;
    end else if (step) begin
      if (arb) arb_lost <= 1'b1;
      else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            shreg <= shreg << 1;
            cnt   <= cnt_dec(cnt);
          end
          ST_AACK: begin
            if (rx_bit) nack <= 1'b1;
            else begin
              shreg <= SH_W'(wbuf) << (SH_W - DATA_W);
              cnt   <= CNT_W'(DATA_W - 1);
            end
          end
          ST_WACK: if (rx_bit) nack <= 1'b1;
          ST_RDATA: begin
            rdata <= shift_in(rdata, rx_bit);
            cnt   <= cnt_dec(cnt);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_txn_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              be_req_o,
  output logic [2:0]        be_cmd_o,
  output logic              be_bit_o,
  input  logic              be_done_i,
  input  logic              be_rx_i,
  input  logic              be_arb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nack_o,
  output logic              arb_lost_o
);

  txn_st_e state;
  logic    step;
  logic    accept;
  logic    cnt_zero;
  logic    rd_q;

  assign be_req_o = (state != ST_IDLE) && (state != ST_DONE);
  assign step     = be_req_o && be_done_i;
  assign accept   = start_i && (state == ST_IDLE);
  assign be_cmd_o = cmd_for(state);
  assign busy_o   = (state != ST_IDLE);
  assign done_o   = (state == ST_DONE);

  i2c_txn_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .step     (step),
    .rx_bit   (be_rx_i),
    .arb      (be_arb_i),
    .rd_q     (rd_q),
    .cnt_zero (cnt_zero),
    .state    (state)
  );

  i2c_txn_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .accept   (accept),
    .step     (step),
    .rx_bit   (be_rx_i),
    .arb      (be_arb_i),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wdata_i  (wdata_i),
    .tx_bit   (be_bit_o),
    .cnt_zero (cnt_zero),
    .rd_q     (rd_q),
    .rdata    (rdata_o),
    .nack     (nack_o),
    .arb_lost (arb_lost_o)
  );

endmodule

// File: rtl/i2c_txn_chk.sv
module i2c_txn_chk
  import i2c_txn_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       be_req_o,
  input logic [2:0] be_cmd_o,
  input logic       be_bit_o,
  input logic       be_done_i,
  input logic       be_rx_i,
  input logic       be_arb_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       nack_o,
  input logic       arb_lost_o
);

  wire ev_step = be_req_o && be_done_i;

  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !be_req_o);

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_o && !be_done_i) |=> (be_req_o && $stable(be_cmd_o) && $stable(be_bit_o)));

  // R6
  nack_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && be_cmd_o == CMD_RECV_ACK && be_rx_i && !be_arb_i)
      |=> (nack_o && be_cmd_o == CMD_STOP));

  // R7
  arb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && be_arb_i) |=> (done_o && arb_lost_o && !be_req_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R9
  busy_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

bind i2c_txn_seq i2c_txn_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .be_req_o   (be_req_o),
  .be_cmd_o   (be_cmd_o),
  .be_bit_o   (be_bit_o),
  .be_done_i  (be_done_i),
  .be_rx_i    (be_rx_i),
  .be_arb_i   (be_arb_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .nack_o     (nack_o),
  .arb_lost_o (arb_lost_o)
);

// File: tb/i2c_txn_seq_tb.sv
module i2c_txn_seq_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [6:0] addr;
    logic       rd;
    logic [7:0] wdata;
    logic [7:0] sdata;
    logic       aack;   // 1 = target acks address
    logic       dack;   // 1 = target acks write data
    logic [5:0] arb_at; // completion index reporting arbitration loss, 63 = none
    logic [2:0] lat;    // engine delay in cycles
    logic       poke;   // extra start pulse mid-transaction
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{7'h50, 1'b0, 8'hA5, 8'h00, 1'b1, 1'b1, 6'd63, 3'd0, 1'b0},
    '{7'h3C, 1'b1, 8'h00, 8'h96, 1'b1, 1'b1, 6'd63, 3'd2, 1'b0},
    '{7'h11, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b1, 6'd63, 3'd1, 1'b0},
    '{7'h22, 1'b0, 8'h0F, 8'h00, 1'b1, 1'b0, 6'd63, 3'd0, 1'b0},
    '{7'h7F, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1, 6'd63, 3'd1, 1'b0},
    '{7'h6B, 1'b0, 8'h33, 8'h00, 1'b1, 1'b1, 6'd3,  3'd0, 1'b0},
    '{7'h05, 1'b1, 8'h00, 8'hC3, 1'b1, 1'b1, 6'd12, 3'd1, 1'b0},
    '{7'h00, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1, 6'd63, 3'd5, 1'b0},
    '{7'h44, 1'b0, 8'h81, 8'h00, 1'b1, 1'b1, 6'd0,  3'd0, 1'b0},
    '{7'h2A, 1'b1, 8'h00, 8'h5E, 1'b1, 1'b1, 6'd63, 3'd1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       be_req_o;
  logic [2:0] be_cmd_o;
  logic       be_bit_o;
  logic       be_done_i = 1'b0;
  logic       be_rx_i = 1'b0;
  logic       be_arb_i = 1'b0;
  logic       busy_o, done_o, nack_o, arb_lost_o;
  logic [7:0] rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_txn_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .be_req_o(be_req_o), .be_cmd_o(be_cmd_o), .be_bit_o(be_bit_o),
    .be_done_i(be_done_i), .be_rx_i(be_rx_i), .be_arb_i(be_arb_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .nack_o(nack_o), .arb_lost_o(arb_lost_o)
  );

  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 0;
  vec_t cur;

  // command log written by the engine model
  logic [2:0] tr_cmd [32];
  logic       tr_bit [32];
  int         tr_n = 0;
  int         hold_err = 0;
  // expected log
  logic [2:0] exp_cmd [32];
  logic       exp_bit [32];
  int         exp_n;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Bit engine model: completes a command lat cycles after it appears.
  int   wcnt = 0, k = 0, ackn = 0, rbn = 0;
  logic [2:0] hc;
  logic       hb;
  always @(negedge clk) begin
    if (!rst_n) begin
      be_done_i = 0; be_rx_i = 0; be_arb_i = 0; wcnt = 0;
    end else if (be_done_i) begin
      be_done_i = 0; be_rx_i = 0; be_arb_i = 0; wcnt = 0;
    end else if (be_req_o) begin
      if (wcnt > 0 && (be_cmd_o != hc || be_bit_o != hb)) hold_err++;
      hc = be_cmd_o; hb = be_bit_o;
      if (wcnt >= int'(cur.lat)) begin
        if (be_cmd_o == 3'd1) begin k = 0; tr_n = 0; ackn = 0; rbn = 0; end
        if (tr_n < 32) begin tr_cmd[tr_n] = be_cmd_o; tr_bit[tr_n] = be_bit_o; tr_n++; end
        be_rx_i = 1'b0;
        if (be_cmd_o == 3'd6) begin
          be_rx_i = (ackn == 0) ? !cur.aack : !cur.dack;
          ackn++;
        end else if (be_cmd_o == 3'd4) begin
          be_rx_i = cur.sdata[7-rbn];
          rbn++;
        end
        be_arb_i = (k == int'(cur.arb_at));
        k++;
        be_done_i = 1;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic push(input logic [2:0] c, input logic b);
    exp_cmd[exp_n] = c; exp_bit[exp_n] = b; exp_n++;
  endtask

  task automatic build_exp(input vec_t v);
    exp_n = 0;
    push(3'd1, 1'b1);
    for (int i = 6; i >= 0; i--) push(3'd3, v.addr[i]);
    push(3'd3, v.rd);
    push(3'd6, 1'b1);
    if (!v.aack) push(3'd2, 1'b1);
    else if (v.rd) begin
      for (int i = 0; i < 8; i++) push(3'd4, 1'b1);
      push(3'd5, 1'b1);
      push(3'd2, 1'b1);
    end else begin
      for (int i = 7; i >= 0; i--) push(3'd3, v.wdata[i]);
      push(3'd6, 1'b1);
      push(3'd2, 1'b1);
    end
  endtask

  task automatic run_txn(input vec_t v);
    int  full_n, to;
    bit  ok, e_arb, e_nack;
    cur = v;
    build_exp(v);
    full_n = exp_n;
    e_arb  = int'(v.arb_at) < full_n;
    if (e_arb) exp_n = int'(v.arb_at) + 1;
    // address NACK completes at index 9, data NACK at index 18
    e_nack = (!v.aack && int'(v.arb_at) > 9) ||
             (v.aack && !v.rd && !v.dack && int'(v.arb_at) > 18);
    hold_err = 0;
    addr_i = v.addr; rd_i = v.rd; wdata_i = v.wdata; start_i = 1;
    @(negedge clk);
    start_i = 0;
    // R8 busy after accept; R7 R6 flags cleared by the accepted start
    check(busy_o === 1'b1, "R8 busy after accept", busy_o, 1);
    check(arb_lost_o === 1'b0 && nack_o === 1'b0, "R7 R6 flags clear on start",
          {arb_lost_o, nack_o}, 0);
    if (v.poke) begin
      repeat (3) @(negedge clk);
      addr_i = ~v.addr; rd_i = ~v.rd; start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    to = 0;
    while (done_o !== 1'b1 && to < 2000) begin @(negedge clk); to++; end
    check(to < 2000, "R8 done reached", to, 0);
    ok = (tr_n == exp_n);
    for (int i = 0; i < 32; i++)
      if (ok && i < exp_n)
        if (tr_cmd[i] != exp_cmd[i] ||
            ((exp_cmd[i] == 3'd3 || exp_cmd[i] == 3'd5) && tr_bit[i] != exp_bit[i]))
          ok = 0;
    // R2 R4 R5 R6 R7 R9 ordered command log
    check(ok, "R2 R4 R5 R6 R7 R9 command log length", tr_n, exp_n);
    check(nack_o === e_nack, "R6 nack flag", nack_o, e_nack);
    check(arb_lost_o === e_arb, "R7 arbitration flag", arb_lost_o, e_arb);
    if (v.rd && v.aack && !e_arb)
      check(rdata_o === v.sdata, "R5 read data", rdata_o, v.sdata);
    check(hold_err == 0, "R3 command hold", hold_err, 0);
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0 && be_req_o === 1'b0,
          "R8 single done pulse then idle", {done_o, busy_o, be_req_o}, 0);
    if (e_arb) begin
      repeat (4) @(negedge clk);
      check(arb_lost_o === 1'b1, "R7 sticky while idle", arb_lost_o, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o === 0 && be_req_o === 0 && done_o === 0 && nack_o === 0 &&
          arb_lost_o === 0 && be_cmd_o === 3'd0, "R1 reset state",
          {busy_o, be_req_o, done_o, nack_o, arb_lost_o, be_cmd_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy_o === 0 && be_cmd_o === 3'd0, "R1 idle after reset", busy_o, 0);
    for (int i = 0; i < NV; i++) run_txn(VECS[i]);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule